// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block controls one bank of 32 general-purpose I/O lines, organised as four 8-bit ports. Port A occupies byte lane 0 (bits 7:0), port B lane 1, port C lane 2 and port D lane 3. Software reaches it through a simple single-cycle register bus with per-byte write enables. Each port can therefore be changed without a read-modify-write of its neighbours.

Each line has four controls: a direction bit, an output value, and a bit that hands the pad to a dedicated peripheral. A two-bit trigger field selects which edges of the synchronized input raise an event. Events latch into a pending register that software clears by writing ones. A single interrupt line is asserted whenever any bit is pending.

The word map uses bus_addr[4:2]; bits 1:0 are ignored:

| Offset | Register |
| --- | --- |
| 0x00 | Peripheral select |
| 0x08 | Direction |
| 0x0C | Data |
| 0x10 | Pending |
| 0x14 | Triggers for ports A and B |
| 0x18 | Triggers for ports C and D |

Offsets 0x04 and 0x1C are unmapped.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every line is an input (pad_oe = 0), all registers read 0, nothing is pending and irq is 0.
- R2: A direction bit of 1 makes its line an output and 0 makes it an input. pad_oe equals direction AND NOT peripheral-select. pad_out equals the data register written at 0x0C.
- R3: Setting a peripheral-select bit (0x00) to 1 forces that line's pad_oe to 0 and drives the matching periph_sel bit to 1.
- R4: A write changes only the byte lanes whose bus_be bit is 1; the other lanes keep their value.
- R5: Reading 0x0C returns, per line, the written output value if the line is an output, or else the pad level after a two-flop synchronizer. A pad change becomes readable after the second rising clock edge.
- R6: The trigger field for line i (port p = i/8, pin n = i%8) sits at bit 16*(p%2)+2n. Ports A and B use the word at 0x14 and ports C and D use the word at 0x18. Field code 0 means no event, 1 means falling edge, 2 means rising edge and 3 means both edges.
- R7: A selected edge on a pad sets its pending bit, and irq, on the third rising clock edge after the pad changes. Unselected edges never set it.
- R8: Writing 1 to a pending bit at 0x10 clears it. Writing 0, or writing with that lane's byte enable low, leaves it set.
- R9: If an edge is detected in the same cycle that software clears the bit, the bit stays set.
- R10: irq is registered and equals the OR of all pending bits. It stays high until the last pending bit is cleared.
- R11: Offsets 0x04 and 0x1C read as 0, and writes to them change no register.
- R12: With a trigger field of 0, pad toggles leave the pending register at 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits 4:2 select the word |
| bus_be | input | 4 | Byte-lane write enables, lane n = port n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| periph_sel | output | 32 | 1 = pad owned by a dedicated peripheral |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge detected in the same cycle that software clears its pending bit. The bench first leaves a both-edges line pending. It then toggles the pad and issues the clear two clock edges later, so the write lands exactly on the edge where the synchronized change is seen. A behavioural model follows the synchronizer delay, the trigger decoding and the clear priority, and is compared on every clock. Directed reads separately confirm the per-lane trigger field positions and the exact cycle in which irq rises.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic [31:0] periph_sel,
  output logic        irq
);
  localparam int LINES = 32;
  localparam logic [2:0] SLOT_SEL  = 3'd0;
  localparam logic [2:0] SLOT_DIR  = 3'd2;
  localparam logic [2:0] SLOT_DAT  = 3'd3;
  localparam logic [2:0] SLOT_PEND = 3'd4;
  localparam logic [2:0] SLOT_TLO  = 3'd5;
  localparam logic [2:0] SLOT_THI  = 3'd6;

  logic [LINES-1:0]   sel_q, dir_q, out_q, pend_q, pend_d;
  logic [LINES-1:0]   meta_q, sync_q, last_q, hit, clr, lane_mask;
  logic [2*LINES-1:0] trig_q;
  logic [2:0]         slot;
  logic               wr;

  assign slot      = bus_addr[4:2];
  assign wr        = bus_en & bus_we;
  assign lane_mask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  always_comb begin
    for (int i = 0; i < LINES; i++)
      hit[i] = (sync_q[i] & ~last_q[i] & trig_q[2*i+1]) |
               (~sync_q[i] & last_q[i] & trig_q[2*i]);
  end

  assign clr    = (wr && slot == SLOT_PEND) ? (bus_wdata & lane_mask) : '0;
  assign pend_d = (pend_q & ~clr) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      trig_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq    <= |pend_d;
      if (wr) begin
        case (slot)
          SLOT_SEL: sel_q <= (sel_q & ~lane_mask) | (bus_wdata & lane_mask);
          SLOT_DIR: dir_q <= (dir_q & ~lane_mask) | (bus_wdata & lane_mask);
          SLOT_DAT: out_q <= (out_q & ~lane_mask) | (bus_wdata & lane_mask);
          SLOT_TLO: trig_q[31:0]  <= (trig_q[31:0] & ~lane_mask) | (bus_wdata & lane_mask);
          SLOT_THI: trig_q[63:32] <= (trig_q[63:32] & ~lane_mask) | (bus_wdata & lane_mask);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (slot)
      SLOT_SEL:  bus_rdata = sel_q;
      SLOT_DIR:  bus_rdata = dir_q;
      SLOT_DAT:  bus_rdata = (dir_q & out_q) | (~dir_q & sync_q);
      SLOT_PEND: bus_rdata = pend_q;
      SLOT_TLO:  bus_rdata = trig_q[31:0];
      SLOT_THI:  bus_rdata = trig_q[63:32];
      default:   bus_rdata = '0;
    endcase
  end

  assign pad_out    = out_q;
  assign pad_oe     = dir_q & ~sel_q;
  assign periph_sel = sel_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [2:0]  slot,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic [31:0] hit,
  input logic [31:0] pend_q,
  input logic [31:0] pad_oe,
  input logic [31:0] periph_sel,
  input logic        irq
);
  for (genvar i = 0; i < 32; i++) begin : g_line
    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && slot == 3'd4 && bus_be[i/8] && bus_wdata[i] && !hit[i]) |=> !pend_q[i]);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !hit[i]) |=> !pend_q[i]);
    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend_q[i]);
  end

  assert_irq_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (pend_q != '0));

  assert_dir_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && slot == 3'd2 && bus_be[0]) |=> pad_oe[7:0] == ($past(bus_wdata[7:0]) & ~periph_sel[7:0]));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .slot(slot), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .hit(hit), .pend_q(pend_q), .pad_oe(pad_oe),
  .periph_sel(periph_sel), .irq(irq)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/100ps
module gpio_edge_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe, periph_sel;
  logic        irq;

  gpio_edge_bank u_gpio_edge_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .periph_sel(periph_sel), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit [31:0] m_sel, m_dir, m_out, m_pend, p1, p2, p3;
  bit [63:0] m_trig;
  bit        m_irq;

  function automatic bit [31:0] m_read(input logic [4:0] a);
    case (a & 5'h1C)
      5'h00: return m_sel;
      5'h08: return m_dir;
      5'h0C: return (m_dir & m_out) | (~m_dir & p2);
      5'h10: return m_pend;
      5'h14: return m_trig[31:0];
      5'h18: return m_trig[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_dir = 0; m_out = 0; m_pend = 0; m_trig = 0; m_irq = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit [31:0] lm, hv, cv;
      for (int b = 0; b < 4; b++) lm[b*8 +: 8] = bus_be[b] ? 8'hFF : 8'h00;
      for (int i = 0; i < 32; i++) begin
        int code;
        code = m_trig[2*i +: 2];
        hv[i] = ((code == 2 || code == 3) && p2[i] && !p3[i]) ||
                ((code == 1 || code == 3) && !p2[i] && p3[i]);
      end
      cv = 0;
      if (bus_en && bus_we) begin
        case (bus_addr & 5'h1C)
          5'h00: m_sel = (m_sel & ~lm) | (bus_wdata & lm);
          5'h08: m_dir = (m_dir & ~lm) | (bus_wdata & lm);
          5'h0C: m_out = (m_out & ~lm) | (bus_wdata & lm);
          5'h10: cv = bus_wdata & lm;
          5'h14: m_trig[31:0]  = (m_trig[31:0] & ~lm) | (bus_wdata & lm);
          5'h18: m_trig[63:32] = (m_trig[63:32] & ~lm) | (bus_wdata & lm);
          default: ;
        endcase
      end
      m_pend = (m_pend & ~cv) | hv;
      m_irq = (m_pend != 0);
      p3 = p2; p2 = p1; p1 = pad_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 pad_oe", pad_oe, m_dir & ~m_sel);
      chk("R2 pad_out", pad_out, m_out);
      chk("R3 periph_sel", periph_sel, m_sel);
      chk("R10 irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R5 rdata", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    step();
    bus_en = 0; bus_we = 0; bus_be = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    step();
    bus_en = 0;
  endtask

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    rd(5'h10, v); chk("R1 pending", v, 0);
    rd(5'h14, v); chk("R1 trig AB", v, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    // R4 byte lanes, R2 direction
    wr(5'h08, 4'b0101, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R4 dir lanes", v, 32'h00FF_00FF);
    chk("R2 oe follows dir", pad_oe, 32'h00FF_00FF);
    wr(5'h0C, 4'hF, 32'hA5A5_5A5A);
    chk("R2 pad_out", pad_out, 32'hA5A5_5A5A);
    // R5 data readback and synchronizer latency
    pad_in = 32'hFFFF_0000;
    step();
    rd(5'h0C, v); chk("R5 before sync", v, 32'h00A5_005A);
    rd(5'h0C, v); chk("R5 after sync", v, 32'hFFA5_005A);
    pad_in = 0;
    wr(5'h08, 4'hF, 0);
    repeat (4) step();
    rd(5'h10, v); chk("R12 no trigger no pend", v, 0);
    // R3 peripheral select
    wr(5'h00, 4'b0010, 32'hFFFF_FFFF);
    wr(5'h08, 4'hF, 32'hFFFF_FFFF);
    chk("R3 oe masked", pad_oe, 32'hFFFF_00FF);
    chk("R3 periph_sel", periph_sel, 32'h0000_FF00);
    wr(5'h00, 4'hF, 0);
    wr(5'h08, 4'hF, 0);
    // R6 trigger layout: line3 rise, line13 fall, line20 both
    wr(5'h14, 4'hF, 32'h0400_0080);
    wr(5'h18, 4'hF, 32'h0000_0300);
    rd(5'h14, v); chk("R6 trig AB", v, 32'h0400_0080);
    rd(5'h18, v); chk("R6 trig CD", v, 32'h0000_0300);
    // R7 latency
    pad_in[3] = 1;
    step(); step();
    chk("R7 not yet", {31'b0, irq}, 0);
    step();
    chk("R7 irq on third edge", {31'b0, irq}, 1);
    rd(5'h10, v); chk("R7 rising line3", v, 32'h0000_0008);
    pad_in[3] = 0;
    repeat (4) step();
    rd(5'h10, v); chk("R6 falling ignored on rise-only", v, 32'h0000_0008);
    // R8 write-one-to-clear
    wr(5'h10, 4'hF, 0);
    rd(5'h10, v); chk("R8 zero write keeps", v, 32'h0000_0008);
    wr(5'h10, 4'b1110, 32'h0000_0008);
    rd(5'h10, v); chk("R8 disabled lane keeps", v, 32'h0000_0008);
    wr(5'h10, 4'b0001, 32'h0000_0008);
    rd(5'h10, v); chk("R8 cleared", v, 0);
    chk("R10 irq low", {31'b0, irq}, 0);
    // falling-only line13
    pad_in[13] = 1;
    repeat (4) step();
    rd(5'h10, v); chk("R6 rise ignored on fall-only", v, 0);
    pad_in[13] = 0;
    repeat (4) step();
    rd(5'h10, v); chk("R6 fall line13", v, 32'h0000_2000);
    // both-edge line20
    pad_in[20] = 1;
    repeat (4) step();
    rd(5'h10, v); chk("R6 both line20", v, 32'h0010_2000);
    wr(5'h10, 4'b0010, 32'h0000_2000);
    chk("R10 irq held by other bit", {31'b0, irq}, 1);
    rd(5'h10, v); chk("R8 only line13 cleared", v, 32'h0010_0000);
    // R9 coincident edge and clear
    pad_in[20] = 0;
    step(); step();
    wr(5'h10, 4'b0100, 32'h0010_0000);
    rd(5'h10, v); chk("R9 edge beats clear", v, 32'h0010_0000);
    wr(5'h10, 4'b0100, 32'h0010_0000);
    rd(5'h10, v); chk("R9 later clear", v, 0);
    chk("R10 irq drops", {31'b0, irq}, 0);
    // R11 unmapped offsets
    wr(5'h04, 4'hF, 32'hFFFF_FFFF);
    wr(5'h1C, 4'hF, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R11 0x04", v, 0);
    rd(5'h1C, v); chk("R11 0x1C", v, 0);
    rd(5'h14, v); chk("R11 trig intact", v, 32'h0400_0080);
    rd(5'h08, v); chk("R11 dir intact", v, 0);
    // R12 disabled triggers
    wr(5'h14, 4'hF, 0);
    wr(5'h18, 4'hF, 0);
    pad_in = 32'hFFFF_FFFF;
    repeat (4) step();
    pad_in = 0;
    repeat (4) step();
    rd(5'h10, v); chk("R12 pend stays zero", v, 0);
    chk("R12 irq low", {31'b0, irq}, 0);
    report();
  end
endmodule